// File: doc/BRIEF.md
# Serial Gain-Control Register Block

This block is a four-wire serial slave that sets the gain of a four-channel step attenuator. A host lowers chip select, clocks in one 16-bit frame and raises chip select again. The first byte is a command and the second is data. Each channel has its own control register, which holds a 5-bit attenuation code, a power-on bit and a power-level bit. The block drives those fields straight out as per-channel control lines. A fifth address is a write-only adjust register. A write to it moves the attenuation of every channel by one step down, up, or not at all. This lets the host correct all four gains in one frame during automatic gain control.

The serial pins are sampled on the system clock. One register stage feeds an edge detector, so each clock level and the chip-select setup time must last at least two system clocks. A state machine tracks the frame with these states:

- `ST_IDLE`: chip select is high.
- `ST_CMD`: command bits are being received. It is entered from `ST_IDLE` when chip select is seen low.
- `ST_DATA`: data bits are being received. It is entered after the eighth rising clock.
- `ST_FULL`: all 16 bits have arrived. It is entered after the sixteenth rising clock.
- `ST_OVER`: the frame ran long. It is entered on any further rising clock.

Every state returns to `ST_IDLE` when chip select is seen high. Leaving `ST_FULL` that way commits a valid write.

Top module: `gainspi_ctrl`

## Requirements
- R1: After reset every channel register is 00h, so every channel reads attenuation 0, power off and low power level.
- R2: A frame is shifted in MSB first on rising serial-clock edges, command byte first. Command bit 7 is 1 for read and 0 for write. Command bits 6:3 are reserved and must be zero. Command bits 2:0 give the address: 0 to 3 select channels A to D, and 4 selects the adjust register.
- R3: A write to a channel address commits when chip select is released after exactly 16 rising edges. The control outputs change on the second system-clock edge after chip select is seen high. Data bit 6 is power on, bit 5 is high power level, and bits 4:0 are the attenuation code. Bit 7 is stored as 0.
- R4: A frame released after fewer or more than 16 rising edges changes no register.
- R5: A write with nonzero reserved command bits, or to an address above 4, changes no register.
- R6: On a read, the addressed register is sent MSB first. Each bit is launched on a falling edge, from the 8th through the 15th falling edge. The data byte on the input is ignored and changes no register.
- R7: A read of the adjust register or of an address above 4 returns 00h.
- R8: The data-out enable is high exactly while chip select is low. Data out is 0 for the whole command byte.
- R9: The adjust data byte holds two bits per channel: A in bits 1:0, B in 3:2, C in 5:4 and D in 7:6. Code 00 holds, 01 lowers the attenuation by one, 10 raises it by one, and 11 holds. Power bits are not changed.
- R10: Adjust steps saturate: lowering from 0 stays at 0, and raising from 31 stays at 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out value |
| spi_miso_en | output | 1 | Output-driver enable for data out; the pad is high impedance when low |
| att_code | output | NUM_CH*5 | Per-channel attenuation codes, channel A in the low bits |
| pwr_on | output | NUM_CH | Per-channel power enable |
| pwr_hi | output | NUM_CH | Per-channel high power level |

## Verification
Writes to every channel use distinct data patterns, including the reserved data bit set, so field positions and channel decoding are told apart. Reads are sent with an all-ones data byte, which shows that the input data is ignored and that bit order and falling-edge launch timing are correct. Frames of 15 and 17 clocks, a nonzero reserved field and an out-of-range address are all tried, and each must leave the outputs untouched. Adjust writes mix all four codes across the channels and start from 0 and 31, which exposes swapped channel fields, wrong directions and wrap-around.

// File: rtl/gainspi_pkg.sv
package gainspi_pkg;
    localparam int CMD_W  = 8;
    localparam int DAT_W  = 8;
    localparam int ADDR_W = 3;
    localparam int ATT_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_FULL,
        ST_OVER
    } frame_st_e;

    typedef enum logic [1:0] {
        FA_HOLD = 2'b00,
        FA_DOWN = 2'b01,
        FA_UP   = 2'b10,
        FA_RSVD = 2'b11
    } fa_code_e;

    typedef struct packed {
        logic             rsvd;
        logic             pwr_on;
        logic             pwr_hi;
        logic [ATT_W-1:0] att;
    } chan_reg_t;
endpackage

// File: rtl/gs_pin_sampler.sv
module gs_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    input  logic sck,
    input  logic mosi,
    output logic sel,
    output logic mosi_s,
    output logic sck_rise,
    output logic sck_fall
);
    logic csn_q, sck_q, sck_qq, mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_q  <= 1'b1;
            sck_q  <= 1'b0;
            sck_qq <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            csn_q  <= csn;
            sck_q  <= sck;
            sck_qq <= sck_q;
            mosi_q <= mosi;
        end
    end

    assign sel      = ~csn_q;
    assign mosi_s   = mosi_q;
    assign sck_rise = sck_q & ~sck_qq & sel;
    assign sck_fall = ~sck_q & sck_qq & sel;
endmodule

// File: rtl/gs_frame_fsm.sv
module gs_frame_fsm
    import gainspi_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              mosi_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic [DAT_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DAT_W-1:0]  wr_data,
    output logic              miso_bit
);
    localparam int BCNT_W = $clog2(CMD_W);
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(CMD_W - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_CH);

    frame_st_e         st_q, st_d;
    logic [BCNT_W-1:0] bit_cnt;
    logic [CMD_W-1:0]  cmd_q;
    logic [DAT_W-1:0]  dat_q;
    logic [DAT_W-1:0]  rd_sh;
    logic              miso_q;
    logic              cmd_ok;
    logic              is_read;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (sel) st_d = ST_CMD;
            ST_CMD: begin
                if (!sel)                                 st_d = ST_IDLE;
                else if (sck_rise && bit_cnt == LAST_BIT) st_d = ST_DATA;
            end
            ST_DATA: begin
                if (!sel)                                 st_d = ST_IDLE;
                else if (sck_rise && bit_cnt == LAST_BIT) st_d = ST_FULL;
            end
            ST_FULL: begin
                if (!sel)          st_d = ST_IDLE;
                else if (sck_rise) st_d = ST_OVER;
            end
            ST_OVER: if (!sel) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // frame shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            cmd_q   <= '0;
            dat_q   <= '0;
        end else if (st_q == ST_IDLE) begin
            bit_cnt <= '0;
            cmd_q   <= '0;
            dat_q   <= '0;
        end else if (sck_rise && (st_q == ST_CMD || st_q == ST_DATA)) begin
            bit_cnt <= bit_cnt + BCNT_W'(1);
            if (st_q == ST_CMD) cmd_q <= {cmd_q[CMD_W-2:0], mosi_s};
            else                dat_q <= {dat_q[DAT_W-2:0], mosi_s};
        end
    end

    assign is_read = cmd_q[CMD_W-1];
    assign cmd_ok  = !cmd_q[CMD_W-1] && (cmd_q[CMD_W-2:ADDR_W] == '0)
                     && (cmd_q[ADDR_W-1:0] <= TOP_ADDR);

    // outputs: commit strobe and read-back launch
    always_comb begin
        wr_en = (st_q == ST_FULL) && !sel && cmd_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso_q <= 1'b0;
            rd_sh  <= '0;
        end else if (st_q == ST_IDLE) begin
            miso_q <= 1'b0;
            rd_sh  <= '0;
        end else if (sck_fall && st_q == ST_DATA) begin
            if (bit_cnt == '0) begin
                miso_q <= is_read & rd_data[DAT_W-1];
                rd_sh  <= is_read ? {rd_data[DAT_W-2:0], 1'b0} : '0;
            end else begin
                miso_q <= rd_sh[DAT_W-1];
                rd_sh  <= {rd_sh[DAT_W-2:0], 1'b0};
            end
        end
    end

    assign rd_addr  = cmd_q[ADDR_W-1:0];
    assign wr_addr  = cmd_q[ADDR_W-1:0];
    assign wr_data  = dat_q;
    assign miso_bit = miso_q;

    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> st_q == ST_IDLE);
    p_commit_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q == ST_IDLE) && !wr_en);
    p_cmd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_CMD |-> !miso_q);
    p_byte_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CMD && sel && sck_rise && bit_cnt == LAST_BIT) |=> st_q == ST_DATA);
    p_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FULL && sel && sck_rise) |=> st_q == ST_OVER);
endmodule

// File: rtl/gs_gain_regs.sv
module gs_gain_regs
    import gainspi_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DAT_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DAT_W-1:0]        rd_data,
    output logic [NUM_CH*ATT_W-1:0] att_code,
    output logic [NUM_CH-1:0]       pwr_on,
    output logic [NUM_CH-1:0]       pwr_hi
);
    localparam logic [ATT_W-1:0]  ATT_MAX = '1;
    localparam logic [ADDR_W-1:0] FA_ADDR = ADDR_W'(NUM_CH);

    chan_reg_t ch_q [NUM_CH];
    chan_reg_t ch_d [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic             sel_ch;
        logic             fa_hit;
        fa_code_e         code;
        logic [ATT_W-1:0] att_adj;
        chan_reg_t        nxt;

        assign sel_ch = wr_en && (wr_addr == ADDR_W'(g));
        assign fa_hit = wr_en && (wr_addr == FA_ADDR);
        assign code   = fa_code_e'(wr_data[2*g+1 -: 2]);

        always_comb begin
            att_adj = ch_q[g].att;
            unique case (code)
                FA_DOWN: if (ch_q[g].att != '0)      att_adj = ch_q[g].att - ATT_W'(1);
                FA_UP:   if (ch_q[g].att != ATT_MAX) att_adj = ch_q[g].att + ATT_W'(1);
                default: att_adj = ch_q[g].att;
            endcase
            nxt = ch_q[g];
            if (sel_ch) begin
                nxt.rsvd   = 1'b0;
                nxt.pwr_on = wr_data[6];
                nxt.pwr_hi = wr_data[5];
                nxt.att    = wr_data[ATT_W-1:0];
            end else if (fa_hit) begin
                nxt.att = att_adj;
            end
        end

        assign ch_d[g] = nxt;
        assign att_code[g*ATT_W +: ATT_W] = ch_q[g].att;
        assign pwr_on[g] = ch_q[g].pwr_on;
        assign pwr_hi[g] = ch_q[g].pwr_hi;

        p_sat_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (fa_hit && code == FA_DOWN && ch_q[g].att == '0) |=> ch_q[g].att == '0);
        p_sat_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (fa_hit && code == FA_UP && ch_q[g].att == ATT_MAX) |=> ch_q[g].att == ATT_MAX);
        p_step_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (fa_hit && code == FA_UP && ch_q[g].att != ATT_MAX)
            |=> ch_q[g].att == $past(ch_q[g].att) + ATT_W'(1));
        p_fa_keeps_power_r9: assert property (@(posedge clk) disable iff (!rst_n)
            fa_hit |=> $stable(ch_q[g].pwr_on) && $stable(ch_q[g].pwr_hi));
        p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(ch_q[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) ch_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) ch_q[i] <= ch_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_data = ch_q[i];
        end
    end
endmodule

// File: rtl/gainspi_ctrl.sv
module gainspi_ctrl
    import gainspi_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_csn,
    input  logic                    spi_sck,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic                    spi_miso_en,
    output logic [NUM_CH*ATT_W-1:0] att_code,
    output logic [NUM_CH-1:0]       pwr_on,
    output logic [NUM_CH-1:0]       pwr_hi
);
    logic              sel, mosi_s, sck_rise, sck_fall;
    logic              wr_en, miso_bit;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DAT_W-1:0]  rd_data, wr_data;

    gs_pin_sampler u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .csn      (spi_csn),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .sel      (sel),
        .mosi_s   (mosi_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    gs_frame_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .mosi_s   (mosi_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .miso_bit (miso_bit)
    );

    gs_gain_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .att_code (att_code),
        .pwr_on   (pwr_on),
        .pwr_hi   (pwr_hi)
    );

    assign spi_miso_en = ~spi_csn;
    assign spi_miso    = miso_bit;
endmodule

// File: tb/sim_gainspi_ctrl.sv
module sim_gainspi_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int HALF       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_en;
    logic [NCH*5-1:0] att;
    logic [NCH-1:0] on, hi;

    int checks = 0;
    int fails = 0;
    int m_att [NCH];
    int m_on  [NCH];
    int m_hi  [NCH];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gainspi_ctrl #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_en(miso_en),
        .att_code(att), .pwr_on(on), .pwr_hi(hi)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the reference model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NCH; i++) begin
                chk("R3/R9/R10 attenuation", int'(att[i*5 +: 5]), m_att[i]);
                chk("R3 power on", int'(on[i]), m_on[i]);
                chk("R3 power level", int'(hi[i]), m_hi[i]);
            end
        end
    end

    function automatic void model_apply(logic [7:0] cmd, logic [7:0] dat, int nclk);
        int a;
        if (nclk != 16 || cmd[7] || cmd[6:3] != 4'd0) return;
        a = int'(cmd[2:0]);
        if (a < NCH) begin
            m_on[a]  = int'(dat[6]);
            m_hi[a]  = int'(dat[5]);
            m_att[a] = int'(dat[4:0]);
        end else if (a == NCH) begin
            for (int c = 0; c < NCH; c++) begin
                case (dat[2*c +: 2])
                    2'b01: if (m_att[c] > 0) m_att[c] = m_att[c] - 1;
                    2'b10: if (m_att[c] < 31) m_att[c] = m_att[c] + 1;
                    default: ;
                endcase
            end
        end
    endfunction

    function automatic int exp_read(int a);
        if (a < NCH) return m_on[a] * 64 + m_hi[a] * 32 + m_att[a];
        return 0;
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] cmd, input logic [7:0] dat, input int nclk,
                         output logic [7:0] rd);
        rd = '0;
        @(negedge clk) csn = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nclk; i++) begin
            if (i < 8)       mosi = cmd[7-i];
            else if (i < 16) mosi = dat[15-i];
            else             mosi = 1'b0;
            wait_clk(HALF);
            if (i == 0) chk("R8 driver enabled", int'(miso_en), 1);
            if (i < 8) chk("R8 quiet during command", int'(miso), 0);
            if (i >= 8 && i < 16) rd[15-i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        csn = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 model_apply(cmd, dat, nclk);
        @(negedge clk);
        chk("R8 driver released", int'(miso_en), 0);
        wait_clk(2);
    endtask

    task automatic wr(input logic [7:0] cmd, input logic [7:0] dat, input int nclk);
        logic [7:0] dummy;
        frame(cmd, dat, nclk, dummy);
    endtask

    task automatic rd_chk(string req, input int a);
        logic [7:0] got;
        int exp;
        exp = exp_read(a);
        frame(8'h80 | 8'(a), 8'hFF, 16, got);
        chk(req, int'(got), exp);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_att[i] = 0;
            m_on[i]  = 0;
            m_hi[i]  = 0;
        end
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);

        // R1: reset state
        for (int i = 0; i < NCH; i++) begin
            chk("R1 reset attenuation", int'(att[i*5 +: 5]), 0);
            chk("R1 reset power on", int'(on[i]), 0);
            chk("R1 reset power level", int'(hi[i]), 0);
        end
        chk("R1 driver off after reset", int'(miso_en), 0);
        rd_chk("R1 readback 00h", 0);

        // R2, R3: channel writes with distinct patterns
        wr(8'h00, 8'hFF, 16);
        wr(8'h01, 8'h45, 16);
        wr(8'h02, 8'h20, 16);
        wr(8'h03, 8'h0A, 16);
        chk("R3 ch A att", int'(att[4:0]), 31);
        chk("R3 ch B on", int'(on[1]), 1);
        chk("R3 ch C level", int'(hi[2]), 1);
        chk("R2 ch D att", int'(att[19:15]), 10);

        // R6: read back each channel, data byte of ones ignored
        rd_chk("R6 read ch A (bit 7 stored as 0)", 0);
        rd_chk("R6 read ch B", 1);
        rd_chk("R2 read ch C", 2);
        rd_chk("R6 read ch D", 3);
        chk("R6 read did not write", int'(att[4:0]), 31);

        // R7: adjust register and unused address read as zero
        rd_chk("R7 read adjust", 4);
        rd_chk("R7 read unused", 6);

        // R4: short and long frames discarded
        wr(8'h01, 8'h00, 15);
        chk("R4 short frame", int'(att[9:5]), 5);
        wr(8'h01, 8'h00, 17);
        chk("R4 long frame", int'(on[1]), 1);

        // R5: reserved bits and out-of-range address
        wr(8'h0A, 8'h7F, 16);
        chk("R5 reserved field", int'(att[14:10]), 0);
        wr(8'h06, 8'h7F, 16);
        rd_chk("R5 ch C unchanged", 2);

        // R9: adjust mapping D up, C down, B reserved, A down
        wr(8'h04, 8'h9D, 16);
        chk("R9 ch A down", int'(att[4:0]), 30);
        chk("R9 ch B code 11 holds", int'(att[9:5]), 5);
        chk("R10 ch C low saturate", int'(att[14:10]), 0);
        chk("R9 ch D up", int'(att[19:15]), 11);
        chk("R9 power kept", int'(on[0]), 1);

        // R10: high saturation
        wr(8'h00, 8'h1F, 16);
        wr(8'h04, 8'h02, 16);
        chk("R10 ch A high saturate", int'(att[4:0]), 31);
        wr(8'h04, 8'h00, 16);
        chk("R9 hold code", int'(att[19:15]), 11);
        rd_chk("R10 read ch A", 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule